// File: doc/BRIEF.md
# Dual-Direction Storage Bus Transceiver

This block models an 18-bit bidirectional bus transceiver with its own storage element in each direction. It is a cycle-based model that runs on a fast system clock. A-side data travels to an open-drain B side, and B-side data travels back to a tri-state A side. Each direction has four controls: an active-low output enable, an active-low clock enable, a latch enable that is active high, and a clock strobe. Together these pick one of three storage behaviours: follow the input, hold the stored word, or capture the input on a rising strobe edge.

The strobe of each direction is asynchronous to the system clock. It passes through a two-flop synchroniser and is then edge-detected. Latch enable, clock enable, output enable and data are sampled directly on the system clock. The B side can only pull a bit low or release it, so several such blocks can share one wired-OR backplane. The A side gives out a data word and one enable for the tri-state driver.

Top module: `ubt_xcvr`

## Requirements
- R1: While reset is high, and in the first cycle after it, `a_drv_en` is 0, every `b_pull_low` bit is 0 and every `b_release` bit is 1. Both stored words are cleared to 0.
- R2: If latch enable is 1 at a system clock edge, that direction loads the input word sampled at that edge. The loaded word appears at the outputs after that edge, whatever the clock enable and strobe are doing.
- R3: Let the strobe first be sampled high at edge k, after having been sampled low at edge k-1. If latch enable is 0 and clock enable is 0 at edge k+2, the input word sampled at edge k+2 is stored.
- R4: If clock enable is 1 at the edge where a strobe rise takes effect, and latch enable is 0, the stored word does not change.
- R5: If latch enable is 0 and no strobe rise takes effect, the stored word is held. This holds whether the strobe rests high or low.
- R6: Suppose latch enable is 1 at edge n-1 and 0 at edge n, and a strobe rise takes effect at edge n. The word loaded at edge n-1 is kept, and the input at edge n is not captured.
- R7: The output enable is sampled at each edge and acts from the next cycle. Enable input 1 disables that direction: the A driver enable goes to 0, or all B bits are released. Disabling the outputs does not change the stored word.
- R8: When the A-to-B direction is enabled, B bit i has `b_pull_low[i]`=1 exactly when stored bit i is 0. `b_release[i]` is always the inverse of `b_pull_low[i]`.
- R9: `a_data` carries the stored B-to-A word, and `a_drv_en` is 1 exactly when the B-to-A direction is enabled.
- R10: The two directions are independent. Controls and data of one direction never change the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | A-side word sampled for A-to-B transfer |
| a_data | output | 18 | Word for the A-side tri-state driver |
| a_drv_en | output | 1 | A-side driver enable (1 = drive) |
| b_in | input | 18 | B-side word sampled for B-to-A transfer |
| b_pull_low | output | 18 | Per-bit B-side pull-low enable |
| b_release | output | 18 | Per-bit B-side released indication |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_le | input | 1 | A-to-B latch enable, transparent when 1 |
| ab_strobe | input | 1 | A-to-B asynchronous clock strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_le | input | 1 | B-to-A latch enable, transparent when 1 |
| ba_strobe | input | 1 | B-to-A asynchronous clock strobe |

## Verification
The stored words reach the ports directly, so a wrong stored word shows at the ports as soon as the outputs are enabled. An A-to-B error shows as an inverted bit pattern on `b_pull_low` one cycle after the faulty edge. A B-to-A error shows on `a_data` in that same cycle. A mistimed synchroniser moves the capture edge by one or more cycles. A wrong priority between the latch closing and a strobe edge stores the newer word in place of the one loaded while the latch was open. Either fault shows in the cycle after the edge concerned. A stuck output-enable register shows at once as a driven or released bus in the wrong cycle.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int unsigned NUM_DIRS = 2;
    localparam int unsigned DIR_AB   = 0;
    localparam int unsigned DIR_BA   = 1;

    // Control bundle of one transfer direction
    typedef struct packed {
        logic oe_n;
        logic ce_n;
        logic le;
        logic strobe;
    } dir_ctrl_t;

    // What the storage element does on a given system clock edge
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_FOLLOW  = 2'd1,
        ACT_CAPTURE = 2'd2,
        ACT_CLOSE   = 2'd3
    } store_act_t;

    // Priority: open latch, then latch closing, then enabled strobe edge
    function automatic store_act_t pick_action(
        input logic le,
        input logic le_was,
        input logic rise,
        input logic ce_n
    );
        store_act_t act;
        if (le)
            act = ACT_FOLLOW;
        else if (le_was)
            act = ACT_CLOSE;
        else if (rise && !ce_n)
            act = ACT_CAPTURE;
        else
            act = ACT_HOLD;
        return act;
    endfunction

    function automatic logic act_loads(input store_act_t act);
        return (act == ACT_FOLLOW) || (act == ACT_CAPTURE);
    endfunction

endpackage

// File: rtl/ubt_strobe_sync.sv
module ubt_strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= strobe;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[LAST];
    end

    assign rise = chain[LAST] & ~last_q;
endmodule

// File: rtl/ubt_store_path.sv
module ubt_store_path
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             le,
    input  logic             ce_n,
    input  logic             rise,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic             le_was_q;
    logic [WIDTH-1:0] word_q;
    store_act_t       act;

    always_comb begin
        act = pick_action(le, le_was_q, rise, ce_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            le_was_q <= 1'b0;
            word_q   <= '0;
        end else begin
            le_was_q <= le;
            if (act_loads(act))
                word_q <= din;
        end
    end

    assign dout = word_q;
endmodule

// File: rtl/ubt_dir_path.sv
module ubt_dir_path
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH       = 18,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  dir_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             out_en
);
    logic rise;
    logic en_q;

    ubt_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctrl.strobe),
        .rise   (rise)
    );

    ubt_store_path #(.WIDTH(WIDTH)) i_store (
        .clk  (clk),
        .rst  (rst),
        .le   (ctrl.le),
        .ce_n (ctrl.ce_n),
        .rise (rise),
        .din  (din),
        .dout (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ~ctrl.oe_n;
    end

    assign out_en = en_q;
endmodule

// File: rtl/ubt_open_drain.sv
module ubt_open_drain #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             en,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] pull_low,
    output logic [WIDTH-1:0] released
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            assign pull_low[g] = en & ~word[g];
            assign released[g] = ~pull_low[g];
        end
    endgenerate
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH       = 18,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_data,
    output logic             a_drv_en,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_pull_low,
    output logic [WIDTH-1:0] b_release,
    input  logic             ab_oe_n,
    input  logic             ab_ce_n,
    input  logic             ab_le,
    input  logic             ab_strobe,
    input  logic             ba_oe_n,
    input  logic             ba_ce_n,
    input  logic             ba_le,
    input  logic             ba_strobe
);
    dir_ctrl_t        ctrl   [NUM_DIRS];
    logic [WIDTH-1:0] din    [NUM_DIRS];
    logic [WIDTH-1:0] dout   [NUM_DIRS];
    logic             out_en [NUM_DIRS];

    assign ctrl[DIR_AB] = '{oe_n: ab_oe_n, ce_n: ab_ce_n, le: ab_le, strobe: ab_strobe};
    assign ctrl[DIR_BA] = '{oe_n: ba_oe_n, ce_n: ba_ce_n, le: ba_le, strobe: ba_strobe};
    assign din[DIR_AB]  = a_in;
    assign din[DIR_BA]  = b_in;

    genvar d;
    generate
        for (d = 0; d < NUM_DIRS; d++) begin : g_dir
            ubt_dir_path #(
                .WIDTH       (WIDTH),
                .SYNC_STAGES (SYNC_STAGES)
            ) i_path (
                .clk    (clk),
                .rst    (rst),
                .ctrl   (ctrl[d]),
                .din    (din[d]),
                .dout   (dout[d]),
                .out_en (out_en[d])
            );
        end
    endgenerate

    // B side: open drain toward a wired-OR backplane
    ubt_open_drain #(.WIDTH(WIDTH)) i_bdrv (
        .en       (out_en[DIR_AB]),
        .word     (dout[DIR_AB]),
        .pull_low (b_pull_low),
        .released (b_release)
    );

    // A side: word plus one tri-state enable
    assign a_data   = dout[DIR_BA];
    assign a_drv_en = out_en[DIR_BA];
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int unsigned WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_data,
    input logic             a_drv_en,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_pull_low,
    input logic [WIDTH-1:0] b_release,
    input logic             ab_oe_n,
    input logic             ab_ce_n,
    input logic             ab_le,
    input logic             ba_oe_n,
    input logic             ba_le
);
    logic [1:0] run_cnt;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)                  run_cnt <= 2'd0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    // R1: outputs quiet right after a reset edge
    always @(negedge clk) begin
        if (rst_q) begin
            a_r1_reset_quiet: assert (!a_drv_en && b_pull_low == '0 && b_release == '1);
        end
    end

    // R2 / R8: open latch, enabled output shows the inverted word one cycle later
    a_r2_follow_ab: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd1 && $past(ab_le) && !$past(ab_oe_n)) |-> (b_pull_low == ~$past(a_in)));

    // R9: open latch on B-to-A direction drives the word onto A
    a_r9_follow_ba: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd1 && $past(ba_le) && !$past(ba_oe_n)) |-> (a_drv_en && a_data == $past(b_in)));

    // R7: disabled direction releases its outputs
    a_r7_ab_released: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd1 && $past(ab_oe_n)) |-> (b_pull_low == '0 && b_release == '1));

    a_r7_ba_off: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd1 && $past(ba_oe_n)) |-> !a_drv_en);

    // R4: clock inhibit with latch closed keeps the B-side pattern steady
    a_r4_inhibit_hold: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd2 && $past(ab_ce_n) && !$past(ab_le)
         && !$past(ab_oe_n) && !$past(ab_oe_n, 2)) |-> $stable(b_pull_low));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.WIDTH(WIDTH)) i_ubt_xcvr_chk (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .a_data     (a_data),
    .a_drv_en   (a_drv_en),
    .b_in       (b_in),
    .b_pull_low (b_pull_low),
    .b_release  (b_release),
    .ab_oe_n    (ab_oe_n),
    .ab_ce_n    (ab_ce_n),
    .ab_le      (ab_le),
    .ba_oe_n    (ba_oe_n),
    .ba_le      (ba_le)
);

// File: tb/test_ubt_xcvr.sv
`timescale 1ns/1ps
module test_ubt_xcvr;
    localparam int W = 18;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_data, b_pull_low, b_release;
    logic         a_drv_en;
    logic         ab_oe_n, ab_ce_n, ab_le, ab_strobe;
    logic         ba_oe_n, ba_ce_n, ba_le, ba_strobe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit model_on = 0;

    always #10 clk = ~clk;   // 50 MHz

    ubt_xcvr #(.WIDTH(W), .SYNC_STAGES(2)) i_ubt_xcvr (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_data(a_data), .a_drv_en(a_drv_en),
        .b_in(b_in), .b_pull_low(b_pull_low), .b_release(b_release),
        .ab_oe_n(ab_oe_n), .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_strobe(ab_strobe),
        .ba_oe_n(ba_oe_n), .ba_ce_n(ba_ce_n), .ba_le(ba_le), .ba_strobe(ba_strobe)
    );

    // ---------------- behavioural reference ----------------
    bit [W-1:0] m_word [2];
    bit         m_en   [2];
    bit         m_open [2];
    bit         hist_ab[$];
    bit         hist_ba[$];

    function automatic bit saw_rise(bit h[$]);
        // strobe high two samples ago, low three samples ago
        return h[h.size()-3] && !h[h.size()-4];
    endfunction

    function automatic bit [W-1:0] next_word(bit [W-1:0] cur, bit [W-1:0] din,
                                             bit le, bit was_open, bit rise, bit ce_n);
        if (le)                  return din;
        if (was_open)            return cur;
        if (rise && !ce_n)       return din;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < 2; d++) begin
                m_word[d] = '0; m_en[d] = 0; m_open[d] = 0;
            end
            hist_ab = '{0, 0, 0, 0};
            hist_ba = '{0, 0, 0, 0};
        end else begin
            hist_ab.push_back(ab_strobe);
            hist_ba.push_back(ba_strobe);
            if (hist_ab.size() > 8) void'(hist_ab.pop_front());
            if (hist_ba.size() > 8) void'(hist_ba.pop_front());
            m_word[0] = next_word(m_word[0], a_in, ab_le, m_open[0], saw_rise(hist_ab), ab_ce_n);
            m_word[1] = next_word(m_word[1], b_in, ba_le, m_open[1], saw_rise(hist_ba), ba_ce_n);
            m_open[0] = ab_le;
            m_open[1] = ba_le;
            m_en[0]   = !ab_oe_n;
            m_en[1]   = !ba_oe_n;
        end
    end

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (model_on && !finished) begin
            logic [W-1:0] exp_pull;
            exp_pull = m_en[0] ? ~m_word[0] : '0;
            chk("R8 model b_pull_low", b_pull_low, exp_pull);
            chk("R8 model b_release", b_release, ~exp_pull);
            chk("R9 model a_drv_en", {{(W-1){1'b0}}, a_drv_en}, {{(W-1){1'b0}}, m_en[1]});
            if (m_en[1]) chk("R9 model a_data", a_data, m_word[1]);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [W-1:0] X1 = 18'h2A5C3, X2 = 18'h1F00F, X3 = 18'h30C96,
                             X4 = 18'h0ABCD, X5 = 18'h3E781, X6 = 18'h05A5A,
                             Y1 = 18'h1234F, Y2 = 18'h2F0E1;

    initial begin : stim
        rst = 1;
        a_in = '0; b_in = '0;
        ab_oe_n = 1; ab_ce_n = 1; ab_le = 0; ab_strobe = 0;
        ba_oe_n = 1; ba_ce_n = 1; ba_le = 0; ba_strobe = 0;
        tick(3);
        chk("R1 reset a_drv_en", {{(W-1){1'b0}}, a_drv_en}, '0);
        chk("R1 reset b_pull_low", b_pull_low, '0);
        chk("R1 reset b_release", b_release, '1);
        rst = 0;
        model_on = 1;
        tick(1);
        chk("R1 first cycle b_release", b_release, '1);

        // enable both; stored words must read as zero
        ab_oe_n = 0; ba_oe_n = 0;
        tick(1);
        chk("R1 cleared AB word", b_pull_low, '1);
        chk("R1 cleared BA word", a_data, '0);
        chk("R9 a_drv_en on", {{(W-1){1'b0}}, a_drv_en}, 18'd1);

        // R2: open latch follows, strobe and ce ignored
        ab_le = 1; ab_ce_n = 0; a_in = X1; ab_strobe = 1;
        tick(1);
        chk("R2 follow X1", b_pull_low, ~X1);
        ab_strobe = 0; a_in = X2;
        tick(1);
        chk("R2 follow X2", b_pull_low, ~X2);

        // R5: latch closed, strobe resting, hold
        ab_le = 0; a_in = X4;
        tick(5);
        chk("R5 hold with strobe low", b_pull_low, ~X2);

        // R3: synchronised strobe capture timing
        a_in = X2; ab_strobe = 1;
        tick(1);
        chk("R3 no capture at edge k", b_pull_low, ~X2);
        a_in = X1;
        tick(1);
        chk("R3 no capture at edge k+1", b_pull_low, ~X2);
        a_in = X3;
        tick(1);
        chk("R3 capture at edge k+2", b_pull_low, ~X3);
        a_in = X4;
        tick(4);
        chk("R5 hold with strobe high", b_pull_low, ~X3);

        // R4: clock inhibit
        ab_strobe = 0; ab_ce_n = 1;
        tick(3);
        ab_strobe = 1; a_in = X4;
        tick(5);
        chk("R4 inhibit keeps X3", b_pull_low, ~X3);
        ab_strobe = 0;
        tick(4);

        // R6: latch closing coincides with strobe rise
        ab_ce_n = 0; ab_le = 1; a_in = X5;
        tick(4);
        ab_strobe = 1;
        tick(2);
        ab_le = 0; a_in = X6;
        tick(1);
        chk("R6 latch close wins", b_pull_low, ~X5);
        tick(2);
        chk("R6 value retained", b_pull_low, ~X5);

        // R7: disable and re-enable keeps storage
        ab_oe_n = 1;
        tick(1);
        chk("R7 disabled pull_low", b_pull_low, '0);
        chk("R7 disabled release", b_release, '1);
        ab_oe_n = 0;
        tick(1);
        chk("R7 re-enabled keeps word", b_pull_low, ~X5);

        // R9 / R10: B-to-A direction on its own
        ab_strobe = 0;
        ba_le = 1; b_in = Y1;
        tick(1);
        chk("R9 a_data follow", a_data, Y1);
        chk("R10 AB untouched", b_pull_low, ~X5);
        ba_le = 0; ba_ce_n = 0;
        tick(3);
        ba_strobe = 1; b_in = Y2;
        tick(3);
        chk("R3 BA capture", a_data, Y2);
        chk("R10 AB still untouched", b_pull_low, ~X5);
        ba_oe_n = 1;
        tick(1);
        chk("R7 BA disabled", {{(W-1){1'b0}}, a_drv_en}, '0);
        chk("R10 AB unaffected by BA oe", b_pull_low, ~X5);

        // random phase checked by the reference every cycle
        for (int i = 0; i < 4000; i++) begin
            a_in = W'($urandom); b_in = W'($urandom);
            ab_le = ($urandom % 6) == 0; ba_le = ($urandom % 6) == 0;
            ab_ce_n = ($urandom % 3) == 0; ba_ce_n = ($urandom % 3) == 0;
            ab_oe_n = ($urandom % 8) == 0; ba_oe_n = ($urandom % 8) == 0;
            if (($urandom % 3) == 0) ab_strobe = ~ab_strobe;
            if (($urandom % 3) == 0) ba_strobe = ~ba_strobe;
            tick(1);
        end

        // R1: reset mid-run clears words
        rst = 1;
        tick(1);
        chk("R1 re-reset release", b_release, '1);
        rst = 0; ab_oe_n = 0; ab_le = 0; ab_ce_n = 1;
        tick(1);
        tick(1);
        chk("R1 re-reset cleared word", b_pull_low, '1);
        finish_run();
    end
endmodule